// File: doc/BRIEF.md
# Timer Register Write Completion Status Tracker

This block sits in front of a bank of timer registers whose writes take effect a fixed number of cycles after the bus write, as happens when the bank runs in a slower timer clock domain. It takes a single-cycle write strobe with a byte address and data. It holds each written value in a per-register shadow and counts down a configurable apply latency. When the count ends, it moves the value to the register output. At that same edge it raises a sticky completion flag for that register.

The completion flags are gathered into two 32-bit status words. One word covers the two halves of the free-running counter. The other covers the compare halves, the compare add-increment register and the global control register. Software polls the relevant word after each write and waits for its bit. It then acknowledges the completion by writing a one to that bit at the status word's address. Software allows about a millisecond for the bit to appear, so the apply latency stays bounded and short. A write that lands before the previous write to the same register has been applied restarts the countdown, and only the newest value is applied.

Top module: `timer_wstat_top`

## Requirements
- R1: After reset, all six register outputs read 0 and both status words read 0.
- R2: The tracked registers are at byte offsets 0x100 (counter low), 0x104 (counter high), 0x200 (compare low), 0x204 (compare high), 0x208 (add-increment) and 0x240 (global control). A write to one of them becomes visible on that register's output exactly APPLY_LAT clock edges after the edge that samples the write. Its status bit sets on that same edge, and until then the output keeps its old value.
- R3: Status word bit layout. The counter word (offset 0x110) has bit 0 for counter low and bit 1 for counter high. The control/compare word (offset 0x24C) has bit 0 for compare low, bit 1 for compare high, bit 2 for add-increment and bit 16 for global control. All other bits of both words always read 0.
- R4: A write to a status word's offset clears every bit whose data bit is 1 and leaves bits whose data bit is 0 unchanged. The clear takes effect on the sampling edge.
- R5: A status bit, once set, stays set until it is cleared per R4. Later applied writes to the same register keep it set.
- R6: A write to any offset other than the eight above changes no register output and no status bit.
- R7: A second write to a register whose previous write is still pending discards the earlier value and restarts the latency. The earlier value never appears, and the status bit sets only when the newer value is applied.
- R8: If a status bit is cleared and its register's write is applied on the same edge, the bit ends up set.
- R9: Pending writes to different registers progress independently, each applying on its own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| cnt_lo_o | output | DATA_W | Applied counter low value |
| cnt_hi_o | output | DATA_W | Applied counter high value |
| cmp_lo_o | output | DATA_W | Applied compare low value |
| cmp_hi_o | output | DATA_W | Applied compare high value |
| incr_o | output | DATA_W | Applied add-increment value |
| ctrl_o | output | DATA_W | Applied global control value |
| cnt_wstat_o | output | 32 | Counter write-status word |
| cc_wstat_o | output | 32 | Control/compare write-status word |

## Verification
The bench builds the block with APPLY_LAT set to 3 rather than the default 4, with 32-bit data and 12-bit addresses. This builds the countdown variant of the apply slot. It also lets a restarting rewrite, a clear colliding with an apply, and two overlapping pending registers each fit in a handful of cycles. Those cycles can be checked one by one against a queue-free behavioural model. The single-cycle variant (latency 1) is selected only by elaboration and is not built by this bench.

// File: rtl/timer_wstat_pkg.sv
package timer_wstat_pkg;

   localparam int NUM_TRK = 6;
   localparam int STAT_W  = 32;

   localparam int TRK_CNT_LO = 0;
   localparam int TRK_CNT_HI = 1;
   localparam int TRK_CMP_LO = 2;
   localparam int TRK_CMP_HI = 3;
   localparam int TRK_INCR   = 4;
   localparam int TRK_CTRL   = 5;

   localparam int GRP_CNT = 0;
   localparam int GRP_CC  = 1;

   function automatic int trk_group(int idx);
      return (idx == TRK_CNT_LO || idx == TRK_CNT_HI) ? GRP_CNT : GRP_CC;
   endfunction

   function automatic int trk_bitpos(int idx);
      case (idx)
         TRK_CNT_LO: return 0;
         TRK_CNT_HI: return 1;
         TRK_CMP_LO: return 0;
         TRK_CMP_HI: return 1;
         TRK_INCR:   return 2;
         default:    return 16;
      endcase
   endfunction

   function automatic logic [STAT_W-1:0] group_mask(int grp);
      logic [STAT_W-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_TRK; k++) begin
         if (trk_group(k) == grp) m[trk_bitpos(k)] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/wstat_addr_dec.sv
module wstat_addr_dec
   import timer_wstat_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter logic [NUM_TRK-1:0][ADDR_W-1:0] TRK_OFF = '0,
   parameter logic [ADDR_W-1:0] ST_CNT_OFF = '0,
   parameter logic [ADDR_W-1:0] ST_CC_OFF  = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   output logic [NUM_TRK-1:0] trk_hit_o,
   output logic               cnt_clr_o,
   output logic               cc_clr_o
);

   if (ST_CNT_OFF == ST_CC_OFF) begin : g_bad_st
      $error("status word offsets must differ");
   end

   for (genvar i = 0; i < NUM_TRK; i++) begin : g_hit
      for (genvar j = i + 1; j < NUM_TRK; j++) begin : g_uniq
         if (TRK_OFF[i] == TRK_OFF[j]) begin : g_bad
            $error("tracked register offsets collide");
         end
      end
      if (TRK_OFF[i] == ST_CNT_OFF || TRK_OFF[i] == ST_CC_OFF) begin : g_bad_st_trk
         $error("tracked offset overlaps a status word");
      end
      assign trk_hit_o[i] = wr_en_i && (wr_addr_i == TRK_OFF[i]);
   end

   assign cnt_clr_o = wr_en_i && (wr_addr_i == ST_CNT_OFF);
   assign cc_clr_o  = wr_en_i && (wr_addr_i == ST_CC_OFF);

   // R6: at most one tracked register is selected by a write
   assert_onehot_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trk_hit_o));

   // R6: status word writes never load a tracked register
   assert_clr_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr_o || cc_clr_o) |-> (trk_hit_o == '0));

endmodule

// File: rtl/wstat_apply_slot.sv
module wstat_apply_slot #(
   parameter int DATA_W    = 32,
   parameter int APPLY_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              fire_o,
   output logic [DATA_W-1:0] value_o
);

   localparam int CW = (APPLY_LAT < 2) ? 1 : $clog2(APPLY_LAT);

   if (APPLY_LAT < 1) begin : g_bad_lat
      $error("APPLY_LAT must be at least 1");
   end

   logic              pend_q;
   logic              due;
   logic [DATA_W-1:0] shadow_q;
   logic [DATA_W-1:0] value_q;

   if (APPLY_LAT == 1) begin : g_direct
      assign due = 1'b1;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load_i) begin
            cnt_q <= CW'(APPLY_LAT - 1);
         end else if (pend_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
      assign due = (cnt_q == '0);
   end

   // A load in the same cycle restarts the countdown instead of applying
   assign fire_o = pend_q && due && !load_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         shadow_q <= '0;
         value_q  <= '0;
      end else begin
         if (load_i) begin
            pend_q   <= 1'b1;
            shadow_q <= data_i;
         end else if (fire_o) begin
            pend_q  <= 1'b0;
            value_q <= shadow_q;
         end
      end
   end

   assign value_o = value_q;

   // R2/R7: the output only moves on an apply edge
   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_o |=> $stable(value_o));

   // R7: an apply consumes the pending write unless a new one arrives
   assert_fire_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !pend_q);

endmodule

// File: rtl/wstat_sticky_word.sv
module wstat_sticky_word #(
   parameter int              WIDTH      = 32,
   parameter logic [WIDTH-1:0] TRACK_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_en_i,
   input  logic [WIDTH-1:0] clr_data_i,
   output logic [WIDTH-1:0] word_o
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (TRACK_MASK[b]) begin : g_track
         logic st_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_q <= 1'b0;
            end else begin
               // set has priority over a simultaneous clear
               st_q <= set_i[b] | (st_q & ~(clr_en_i & clr_data_i[b]));
            end
         end
         assign word_o[b] = st_q;

         // R8: a set on this edge is visible afterwards regardless of clears
         assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> word_o[b]);

         // R5: a set bit persists until a one is written to it
         assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (word_o[b] && !(clr_en_i && clr_data_i[b])) |=> word_o[b]);

         // R4: a zero bit only rises through a set
         assert_rise_needs_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!word_o[b] && !set_i[b]) |=> !word_o[b]);
      end else begin : g_none
         logic unused_in;
         assign unused_in  = set_i[b] ^ clr_data_i[b];
         assign word_o[b]  = 1'b0;
      end
   end

endmodule

// File: rtl/timer_wstat_top.sv
module timer_wstat_top
   import timer_wstat_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int APPLY_LAT = 4,
   parameter logic [ADDR_W-1:0] OFF_CNT_LO = ADDR_W'(12'h100),
   parameter logic [ADDR_W-1:0] OFF_CNT_HI = ADDR_W'(12'h104),
   parameter logic [ADDR_W-1:0] OFF_ST_CNT = ADDR_W'(12'h110),
   parameter logic [ADDR_W-1:0] OFF_CMP_LO = ADDR_W'(12'h200),
   parameter logic [ADDR_W-1:0] OFF_CMP_HI = ADDR_W'(12'h204),
   parameter logic [ADDR_W-1:0] OFF_INCR   = ADDR_W'(12'h208),
   parameter logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'(12'h240),
   parameter logic [ADDR_W-1:0] OFF_ST_CC  = ADDR_W'(12'h24C)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] cnt_lo_o,
   output logic [DATA_W-1:0] cnt_hi_o,
   output logic [DATA_W-1:0] cmp_lo_o,
   output logic [DATA_W-1:0] cmp_hi_o,
   output logic [DATA_W-1:0] incr_o,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [31:0]       cnt_wstat_o,
   output logic [31:0]       cc_wstat_o
);

   localparam logic [NUM_TRK-1:0][ADDR_W-1:0] TRK_OFF =
      {OFF_CTRL, OFF_INCR, OFF_CMP_HI, OFF_CMP_LO, OFF_CNT_HI, OFF_CNT_LO};
   localparam logic [STAT_W-1:0] CNT_MASK = group_mask(GRP_CNT);
   localparam logic [STAT_W-1:0] CC_MASK  = group_mask(GRP_CC);

   if (DATA_W < STAT_W) begin : g_bad_w
      $error("DATA_W must cover a status word");
   end
   if (ADDR_W < 10) begin : g_bad_a
      $error("ADDR_W too small for the register map");
   end

   logic [NUM_TRK-1:0]             trk_hit;
   logic [NUM_TRK-1:0]             fire;
   logic [NUM_TRK-1:0][DATA_W-1:0] value;
   logic                           cnt_clr;
   logic                           cc_clr;
   logic [STAT_W-1:0]              cnt_set;
   logic [STAT_W-1:0]              cc_set;

   wstat_addr_dec #(
      .ADDR_W     (ADDR_W),
      .TRK_OFF    (TRK_OFF),
      .ST_CNT_OFF (OFF_ST_CNT),
      .ST_CC_OFF  (OFF_ST_CC)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .trk_hit_o (trk_hit),
      .cnt_clr_o (cnt_clr),
      .cc_clr_o  (cc_clr)
   );

   for (genvar i = 0; i < NUM_TRK; i++) begin : g_slot
      wstat_apply_slot #(
         .DATA_W    (DATA_W),
         .APPLY_LAT (APPLY_LAT)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (trk_hit[i]),
         .data_i  (wr_data),
         .fire_o  (fire[i]),
         .value_o (value[i])
      );
   end

   always_comb begin
      cnt_set = '0;
      cc_set  = '0;
      for (int i = 0; i < NUM_TRK; i++) begin
         if (trk_group(i) == GRP_CNT) cnt_set[trk_bitpos(i)] = fire[i];
         else                         cc_set[trk_bitpos(i)]  = fire[i];
      end
   end

   wstat_sticky_word #(
      .WIDTH      (STAT_W),
      .TRACK_MASK (CNT_MASK)
   ) u_cnt_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (cnt_set),
      .clr_en_i   (cnt_clr),
      .clr_data_i (wr_data[STAT_W-1:0]),
      .word_o     (cnt_wstat_o)
   );

   wstat_sticky_word #(
      .WIDTH      (STAT_W),
      .TRACK_MASK (CC_MASK)
   ) u_cc_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (cc_set),
      .clr_en_i   (cc_clr),
      .clr_data_i (wr_data[STAT_W-1:0]),
      .word_o     (cc_wstat_o)
   );

   assign cnt_lo_o = value[TRK_CNT_LO];
   assign cnt_hi_o = value[TRK_CNT_HI];
   assign cmp_lo_o = value[TRK_CMP_LO];
   assign cmp_hi_o = value[TRK_CMP_HI];
   assign incr_o   = value[TRK_INCR];
   assign ctrl_o   = value[TRK_CTRL];

   // R2: every apply edge raises the matching flag in the right status word
   for (genvar i = 0; i < NUM_TRK; i++) begin : g_chk
      localparam int GRP = trk_group(i);
      localparam int BP  = trk_bitpos(i);
      if (GRP == GRP_CNT) begin : g_cnt
         assert_apply_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> cnt_wstat_o[BP]);
      end else begin : g_cc
         assert_apply_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> cc_wstat_o[BP]);
      end
   end

   // R3: bits outside the layout never read as one
   assert_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_wstat_o & ~CNT_MASK) == '0) && ((cc_wstat_o & ~CC_MASK) == '0));

endmodule

// File: tb/timer_wstat_top_tb.sv
module timer_wstat_top_tb;

   localparam int LAT = 3;
   localparam logic [11:0] A_CNT_LO = 12'h100;
   localparam logic [11:0] A_CNT_HI = 12'h104;
   localparam logic [11:0] A_ST_CNT = 12'h110;
   localparam logic [11:0] A_CMP_LO = 12'h200;
   localparam logic [11:0] A_CMP_HI = 12'h204;
   localparam logic [11:0] A_INCR   = 12'h208;
   localparam logic [11:0] A_CTRL   = 12'h240;
   localparam logic [11:0] A_ST_CC  = 12'h24C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] cnt_lo, cnt_hi, cmp_lo, cmp_hi, incr, ctrl, cnt_ws, cc_ws;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";
   bit    done    = 1'b0;

   always #5 clk = ~clk;

   timer_wstat_top #(.DATA_W(32), .ADDR_W(12), .APPLY_LAT(LAT)) u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .cnt_lo_o (cnt_lo), .cnt_hi_o (cnt_hi), .cmp_lo_o (cmp_lo), .cmp_hi_o (cmp_hi),
      .incr_o (incr), .ctrl_o (ctrl), .cnt_wstat_o (cnt_ws), .cc_wstat_o (cc_ws)
   );

   // Behavioural reference: remaining-cycles counter per register
   int          m_rem [6];
   logic [31:0] m_pend[6];
   logic [31:0] m_val [6];
   bit          m_st  [6];

   function automatic int addr_idx(logic [11:0] a);
      case (a)
         A_CNT_LO: return 0;
         A_CNT_HI: return 1;
         A_CMP_LO: return 2;
         A_CMP_HI: return 3;
         A_INCR:   return 4;
         A_CTRL:   return 5;
         default:  return -1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < 6; r++) begin
            m_rem[r] = 0; m_pend[r] = '0; m_val[r] = '0; m_st[r] = 1'b0;
         end
      end else begin
         bit setm[6];
         int idx;
         idx = wr_en ? addr_idx(wr_addr) : -1;
         for (int r = 0; r < 6; r++) begin
            setm[r] = 1'b0;
            if (r != idx && m_rem[r] > 0) begin
               m_rem[r]--;
               if (m_rem[r] == 0) begin
                  m_val[r] = m_pend[r];
                  setm[r]  = 1'b1;
               end
            end
         end
         if (idx >= 0) begin
            m_rem[idx]  = LAT;
            m_pend[idx] = wr_data;
         end
         if (wr_en && wr_addr == A_ST_CNT) begin
            if (wr_data[0]) m_st[0] = 1'b0;
            if (wr_data[1]) m_st[1] = 1'b0;
         end
         if (wr_en && wr_addr == A_ST_CC) begin
            if (wr_data[0])  m_st[2] = 1'b0;
            if (wr_data[1])  m_st[3] = 1'b0;
            if (wr_data[2])  m_st[4] = 1'b0;
            if (wr_data[16]) m_st[5] = 1'b0;
         end
         for (int r = 0; r < 6; r++) if (setm[r]) m_st[r] = 1'b1;
      end
   end

   function automatic logic [31:0] m_cnt_word();
      return {30'b0, m_st[1], m_st[0]};
   endfunction
   function automatic logic [31:0] m_cc_word();
      logic [31:0] w;
      w = '0;
      w[0] = m_st[2]; w[1] = m_st[3]; w[2] = m_st[4]; w[16] = m_st[5];
      return w;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "model cnt_lo", cnt_lo, m_val[0]);
         chk(cur_req, "model cnt_hi", cnt_hi, m_val[1]);
         chk(cur_req, "model cmp_lo", cmp_lo, m_val[2]);
         chk(cur_req, "model cmp_hi", cmp_hi, m_val[3]);
         chk(cur_req, "model incr",   incr,   m_val[4]);
         chk(cur_req, "model ctrl",   ctrl,   m_val[5]);
         chk(cur_req, "model cnt_ws", cnt_ws, m_cnt_word());
         chk(cur_req, "model cc_ws",  cc_ws,  m_cc_word());
      end
   end

   task automatic step(bit en, logic [11:0] a, logic [31:0] d);
      wr_en = en; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(1'b0, 12'h000, 32'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1";
      chk("R1", "cnt_lo", cnt_lo, 0); chk("R1", "cnt_hi", cnt_hi, 0);
      chk("R1", "cmp_lo", cmp_lo, 0); chk("R1", "cmp_hi", cmp_hi, 0);
      chk("R1", "incr", incr, 0);     chk("R1", "ctrl", ctrl, 0);
      chk("R1", "cnt_ws", cnt_ws, 0); chk("R1", "cc_ws", cc_ws, 0);

      // R2 exact apply latency
      cur_req = "R2";
      step(1'b1, A_CNT_LO, 32'h1100_00A5);
      idle(LAT - 1);
      chk("R2", "cnt_lo early", cnt_lo, 0);
      chk("R2", "cnt_ws early", cnt_ws, 0);
      idle(1);
      chk("R2", "cnt_lo applied", cnt_lo, 32'h1100_00A5);
      chk("R2", "cnt_ws applied", cnt_ws, 32'h1);

      // R3 bit layout
      cur_req = "R3";
      step(1'b1, A_CNT_HI, 32'h22); idle(LAT);
      chk("R3", "cnt_ws both", cnt_ws, 32'h3);
      step(1'b1, A_CMP_LO, 32'h33); idle(LAT);
      step(1'b1, A_CMP_HI, 32'h44); idle(LAT);
      step(1'b1, A_INCR,   32'h55); idle(LAT);
      step(1'b1, A_CTRL,   32'h66); idle(LAT);
      chk("R3", "cc_ws all", cc_ws, 32'h0001_0007);
      chk("R3", "cmp_hi", cmp_hi, 32'h44);
      chk("R3", "ctrl", ctrl, 32'h66);

      // R5 sticky, R4 write-one-to-clear
      cur_req = "R5";
      step(1'b1, A_CNT_LO, 32'h77); idle(LAT);
      chk("R5", "cnt_ws sticky", cnt_ws, 32'h3);
      chk("R5", "cnt_lo rewrite", cnt_lo, 32'h77);
      cur_req = "R4";
      step(1'b1, A_ST_CNT, 32'h0);
      chk("R4", "cnt_ws zero write", cnt_ws, 32'h3);
      step(1'b1, A_ST_CNT, 32'h1);
      chk("R4", "cnt_ws clear bit0", cnt_ws, 32'h2);
      step(1'b1, A_ST_CC, 32'h0001_0004);
      chk("R4", "cc_ws clear 16/2", cc_ws, 32'h3);

      // R6 untracked writes
      cur_req = "R6";
      step(1'b1, 12'h300, 32'hDEAD);
      step(1'b1, 12'h10C, 32'hFFFF_FFFF);
      idle(LAT + 1);
      chk("R6", "cnt_ws", cnt_ws, 32'h2);
      chk("R6", "cc_ws", cc_ws, 32'h3);
      chk("R6", "cnt_lo", cnt_lo, 32'h77);
      chk("R6", "cnt_hi", cnt_hi, 32'h22);

      // R7 restart on rewrite
      cur_req = "R7";
      step(1'b1, A_ST_CC, 32'hFFFF_FFFF);
      chk("R7", "cc_ws cleared", cc_ws, 32'h0);
      step(1'b1, A_CMP_LO, 32'h11);
      idle(1);
      step(1'b1, A_CMP_LO, 32'h88);
      idle(1);
      chk("R7", "cmp_lo at first deadline", cmp_lo, 32'h33);
      chk("R7", "cc_ws at first deadline", cc_ws, 32'h0);
      idle(1);
      chk("R7", "cmp_lo still old", cmp_lo, 32'h33);
      idle(1);
      chk("R7", "cmp_lo newest", cmp_lo, 32'h88);
      chk("R7", "cc_ws newest", cc_ws, 32'h1);

      // R8 set beats clear
      cur_req = "R8";
      step(1'b1, A_CMP_HI, 32'h99);
      idle(LAT - 1);
      step(1'b1, A_ST_CC, 32'h2);
      chk("R8", "cc_ws collide", cc_ws, 32'h3);
      chk("R8", "cmp_hi", cmp_hi, 32'h99);
      cur_req = "R4";
      step(1'b1, A_ST_CC, 32'h2);
      chk("R4", "cc_ws later clear", cc_ws, 32'h1);

      // R9 independent registers
      cur_req = "R9";
      step(1'b1, A_INCR, 32'hAB);
      step(1'b1, A_CTRL, 32'hCD);
      idle(LAT - 1);
      chk("R9", "incr applied", incr, 32'hAB);
      chk("R9", "ctrl pending", ctrl, 32'h66);
      idle(1);
      chk("R9", "ctrl applied", ctrl, 32'hCD);
      chk("R9", "cc_ws both", cc_ws, 32'h0001_0005);

      idle(3);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule